// File: doc/BRIEF.md
# Flash Converter Background Calibration Scheduler

This block runs the digital side of a 4-bit flash converter whose sixteen comparator cells share fifteen reference taps. Because there is one comparator more than there are thresholds, one cell can always be out of service. The scheduler walks a calibration slot of fixed length across the cells in turn. In each slot it steers the chosen cell onto the calibration reference and runs a successive-approximation search on that cell's offset trim code. The selector fabric places the other fifteen cells onto the fifteen thresholds. The comparator decisions are then put back in threshold order and turned into a binary code, so conversion keeps running while the cells are recalibrated one by one.

After reset the block makes one foreground sweep. All sixteen cells are calibrated back to back and the output is marked invalid throughout. After that it rotates in the background without stopping. The threshold assignment changes only when a slot begins. The output-valid flag drops for the sample taken in the first cycle of each slot, which is when the selector fabric is switching.

Top module: `flash_bgcal_top`

## Requirements
- R1: Reset values: `fg_busy`=1, `cal_idx`=0, `code_valid`=0 and every trim code 0.
- R2: A slot lasts 10 clocks. `cal_idx` moves up by one at every slot boundary and wraps from 15 to 0, so one full rotation takes 160 clocks.
- R3: The first 16 slots after reset form the foreground sweep. During it `fg_busy`=1 and `code_valid`=0. `fg_busy` then falls and stays low.
- R4: On `ref_sel`, cell i uses bits [4i+3:4i]. The cell under calibration (`k` = `cal_idx`) gets code 15, the calibration reference. A cell i<k gets threshold code i, and a cell i>k gets threshold code i-1.
- R5: `therm` bit j is the decision of the cell that serves threshold j, sampled on one clock edge and shown from that edge on.
- R6: `code` equals the number of ones in `therm`, so a bubble changes the code by one and does not cause a jump. It updates in the same cycle as `therm`.
- R7: `code_valid` is 1 after an edge that sampled during background rotation, unless that sample was taken in the first cycle of a slot.
- R8: In slot cycles 1 to 6, the trim code of the cell under calibration shows the trial value: the bits already decided, with bit 6-c set in cycle c (MSB first). A decision of 1 on `raw_dec` for that cell keeps the bit and 0 clears it.
- R9: From slot cycle 7 on, the calibrated cell's trim code holds the search result. Trim codes of all other cells stay unchanged.
- R10: `ref_sel` changes only at a slot boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_dec | input | 16 | Comparator decisions, bit i from cell i |
| ref_sel | output | 64 | Reference choice per cell, 4 bits each |
| trim | output | 96 | Offset trim code per cell, 6 bits each |
| cal_idx | output | 4 | Cell under calibration |
| fg_busy | output | 1 | Foreground sweep in progress |
| therm | output | 15 | Threshold-ordered thermometer code |
| code | output | 4 | Binary output code |
| code_valid | output | 1 | Output code is a valid conversion |

## Verification
`ref_sel`, `trim`, `cal_idx` and `fg_busy` are due in the same cycle as the state that drives them. The bench checks them in the cycle right after each edge, using a slot position it derives from its own count of edges since reset. `therm`, `code` and `code_valid` belong to the sample taken one edge earlier. The bench therefore keeps the stimulus and slot position of the previous cycle and compares against those. Trial trim values are checked in slot cycles 1 to 6, and the final result is checked from cycle 7 on.

// File: rtl/flash_cal_pkg.sv
package flash_cal_pkg;

  typedef enum logic {MODE_FG = 1'b0, MODE_BG = 1'b1} cal_mode_e;

  // comparator feeding threshold j while comparator k is calibrated
  function automatic int cmp_for_thr(input int j, input int k);
    return (j < k) ? j : j + 1;
  endfunction

  // threshold served by comparator i while comparator k is calibrated
  function automatic int thr_for_cmp(input int i, input int k);
    return (i < k) ? i : i - 1;
  endfunction

  function automatic int ones(input logic [63:0] v);
    int n;
    n = 0;
    for (int b = 0; b < 64; b++) n += int'(v[b]);
    return n;
  endfunction

endpackage

// File: rtl/cal_seq.sv
module cal_seq
  import flash_cal_pkg::*;
#(
  parameter int NCMP     = 16,
  parameter int SLOT_CYC = 10,
  localparam int IDX_W   = $clog2(NCMP),
  localparam int CNT_W   = $clog2(SLOT_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] idx,
  output cal_mode_e        mode,
  output logic             slot_start,
  output logic             slot_last
);

  assign slot_start = (cnt == '0);
  assign slot_last  = (cnt == CNT_W'(SLOT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      idx  <= '0;
      mode <= MODE_FG;
    end else if (slot_last) begin
      cnt <= '0;
      idx <= (idx == IDX_W'(NCMP - 1)) ? '0 : idx + IDX_W'(1);
      if (mode == MODE_FG && idx == IDX_W'(NCMP - 1)) mode <= MODE_BG;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < SLOT_CYC);

  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_last && idx != IDX_W'(NCMP - 1)) |=> (idx == $past(idx) + IDX_W'(1)));

  assert_fg_no_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BG) |=> (mode == MODE_BG));

endmodule

// File: rtl/sar_trim_bank.sv
module sar_trim_bank #(
  parameter int NCMP     = 16,
  parameter int SAR_W    = 6,
  parameter int SLOT_CYC = 10,
  localparam int IDX_W   = $clog2(NCMP),
  localparam int CNT_W   = $clog2(SLOT_CYC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [IDX_W-1:0]           idx,
  input  logic                       cal_dec,
  output logic [NCMP-1:0][SAR_W-1:0] trim
);

  logic [SAR_W-1:0]            acc;
  logic [SAR_W-1:0]            bit_mask;
  logic [SAR_W-1:0]            trial;
  logic [SAR_W-1:0]            kept;
  logic                        trial_on;
  logic                        wr_en;
  logic [NCMP-1:0][SAR_W-1:0]  store;

  assign trial_on = (int'(cnt) >= 1) && (int'(cnt) <= SAR_W);
  assign wr_en    = (int'(cnt) == SAR_W);

  always_comb begin
    bit_mask = '0;
    if (trial_on) bit_mask = SAR_W'(1) << (SAR_W - int'(cnt));
    trial = acc | bit_mask;
    kept  = cal_dec ? trial : acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      store <= '0;
    end else begin
      if (cnt == '0)    acc <= '0;
      else if (trial_on) acc <= kept;
      if (wr_en) store[idx] <= kept;
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_trim
    assign trim[i] = (trial_on && idx == IDX_W'(i)) ? trial : store[i];
  end

  assert_trim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store));

endmodule

// File: rtl/ref_router.sv
module ref_router #(
  parameter int NCMP    = 16,
  localparam int NTHR   = NCMP - 1,
  localparam int IDX_W  = $clog2(NCMP),
  localparam int REF_W  = $clog2(NTHR + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       slot_start,
  input  logic [IDX_W-1:0]           idx,
  output logic [NCMP-1:0][REF_W-1:0] ref_sel
);

  import flash_cal_pkg::*;

  logic [NCMP-1:0] cal_hit;

  for (genvar i = 0; i < NCMP; i++) begin : g_sel
    always_comb begin
      if (IDX_W'(i) == idx) ref_sel[i] = REF_W'(NTHR);
      else                  ref_sel[i] = REF_W'(thr_for_cmp(i, int'(idx)));
    end
    assign cal_hit[i] = (ref_sel[i] == REF_W'(NTHR));
  end

  assert_one_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cal_hit) == 1);

  assert_ref_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |-> $stable(ref_sel));

endmodule

// File: rtl/therm_enc.sv
module therm_enc
  import flash_cal_pkg::*;
#(
  parameter int NCMP    = 16,
  localparam int NTHR   = NCMP - 1,
  localparam int IDX_W  = $clog2(NCMP),
  localparam int CODE_W = $clog2(NCMP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCMP-1:0]   raw_dec,
  input  logic [IDX_W-1:0]  idx,
  input  cal_mode_e         mode,
  input  logic              slot_start,
  output logic [NTHR-1:0]   therm_q,
  output logic [CODE_W-1:0] code_q,
  output logic              valid_q
);

  logic [NTHR-1:0] therm_d;

  always_comb begin
    for (int j = 0; j < NTHR; j++) therm_d[j] = raw_dec[cmp_for_thr(j, int'(idx))];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      therm_q <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      therm_q <= therm_d;
      code_q  <= CODE_W'(ones(64'(therm_d)));
      valid_q <= (mode == MODE_BG) && !slot_start;
    end
  end

  assert_blank_after_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !valid_q);

  assert_fg_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FG) |=> !valid_q);

endmodule

// File: rtl/flash_bgcal_top.sv
module flash_bgcal_top
  import flash_cal_pkg::*;
#(
  parameter int NCMP     = 16,
  parameter int SAR_W    = 6,
  parameter int SLOT_CYC = 10,
  localparam int NTHR    = NCMP - 1,
  localparam int IDX_W   = $clog2(NCMP),
  localparam int CNT_W   = $clog2(SLOT_CYC),
  localparam int REF_W   = $clog2(NTHR + 1),
  localparam int CODE_W  = $clog2(NCMP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCMP-1:0]         raw_dec,
  output logic [NCMP*REF_W-1:0]   ref_sel,
  output logic [NCMP*SAR_W-1:0]   trim,
  output logic [IDX_W-1:0]        cal_idx,
  output logic                    fg_busy,
  output logic [NTHR-1:0]         therm,
  output logic [CODE_W-1:0]       code,
  output logic                    code_valid
);

  logic [CNT_W-1:0]           cnt;
  logic [IDX_W-1:0]           idx;
  cal_mode_e                  mode;
  logic                       slot_start;
  logic                       slot_last;
  logic                       cal_dec;
  logic [NCMP-1:0][SAR_W-1:0] trim_a;
  logic [NCMP-1:0][REF_W-1:0] ref_a;

  cal_seq #(.NCMP(NCMP), .SLOT_CYC(SLOT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .idx(idx), .mode(mode),
    .slot_start(slot_start), .slot_last(slot_last)
  );

  assign cal_dec = raw_dec[idx];

  sar_trim_bank #(.NCMP(NCMP), .SAR_W(SAR_W), .SLOT_CYC(SLOT_CYC)) u_sar (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .idx(idx), .cal_dec(cal_dec), .trim(trim_a)
  );

  ref_router #(.NCMP(NCMP)) u_route (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .idx(idx), .ref_sel(ref_a)
  );

  therm_enc #(.NCMP(NCMP)) u_enc (
    .clk(clk), .rst_n(rst_n), .raw_dec(raw_dec), .idx(idx), .mode(mode),
    .slot_start(slot_start), .therm_q(therm), .code_q(code), .valid_q(code_valid)
  );

  for (genvar i = 0; i < NCMP; i++) begin : g_flat
    assign ref_sel[i*REF_W +: REF_W] = ref_a[i];
    assign trim[i*SAR_W +: SAR_W]    = trim_a[i];
  end

  assign cal_idx = idx;
  assign fg_busy = (mode == MODE_FG);

  assert_idx_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_last && cal_idx == IDX_W'(NCMP - 1)) |=> (cal_idx == '0));

endmodule

// File: tb/flash_bgcal_top_tb.sv
module flash_bgcal_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;
  localparam int NT = 15;
  localparam int SL = 10;
  localparam int SW = 6;
  localparam int RW = 4;
  localparam int RUN_CYC = 16 * SL + 4 * NC * SL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] raw_dec;
  logic [NC*RW-1:0] ref_sel;
  logic [NC*SW-1:0] trim;
  logic [3:0]    cal_idx;
  logic          fg_busy;
  logic [NT-1:0] therm;
  logic [3:0]    code;
  logic          code_valid;

  int total = 0;
  int bad = 0;
  int m = 0;
  bit run = 0;
  bit done = 0;
  logic [4:0]    vin = '0;
  logic [NT-1:0] bub = '0;
  logic [SW-1:0] tgt [NC];
  logic [SW-1:0] last_cal [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bgcal_top u_dut (
    .clk(clk), .rst_n(rst_n), .raw_dec(raw_dec), .ref_sel(ref_sel), .trim(trim),
    .cal_idx(cal_idx), .fg_busy(fg_busy), .therm(therm), .code(code), .code_valid(code_valid)
  );

  function automatic int k_of(input int mm); return (mm / SL) % NC; endfunction
  function automatic int c_of(input int mm); return mm % SL; endfunction
  function automatic bit fg_of(input int mm); return (mm / SL) < NC; endfunction
  function automatic int exp_ref(input int i, input int k);
    if (i == k) return NT;
    if (i < k) return i;
    return i - 1;
  endfunction
  function automatic int trial_of(input int t, input int c);
    int b;
    b = SW - c;
    return ((t >> (b + 1)) << (b + 1)) | (1 << b);
  endfunction
  function automatic int popc(input logic [NT-1:0] v);
    int n = 0;
    for (int b = 0; b < NT; b++) if (v[b]) n++;
    return n;
  endfunction

  // behavioural comparator bank driven from the bench's own slot position
  always_comb begin
    int kk;
    int t;
    kk = k_of(m);
    for (int i = 0; i < NC; i++) begin
      if (i == kk) raw_dec[i] = (trim[i*SW +: SW] <= tgt[i]);
      else begin
        t = (i < kk) ? i : i - 1;
        raw_dec[i] = (int'(vin) > t) ^ bub[t];
      end
    end
  end

  always @(posedge clk) if (run) m <= m + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (m=%0d)", req, act, exp, m);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NC; i++) begin
      tgt[i] = SW'($urandom_range(0, 63));
      last_cal[i] = '0;
    end
    tgt[0] = '0;        // corner: lowest trim
    tgt[1] = '1;        // corner: highest trim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    // R1 reset state
    check(fg_busy == 1'b1, "R1 fg_busy", int'(fg_busy), 1);
    check(cal_idx == 4'd0, "R1 cal_idx", int'(cal_idx), 0);
    check(code_valid == 1'b0, "R1 code_valid", int'(code_valid), 0);
    check(trim == '0, "R1 trim", int'(trim[31:0]), 0);
  end

  initial begin
    logic [4:0]    p_vin;
    logic [NT-1:0] p_bub;
    logic [NT-1:0] e_th;
    int k;
    int c;
    wait (run);
    p_vin = '0;
    p_bub = '0;
    for (int step = 0; step < RUN_CYC; step++) begin
      k = k_of(m);
      c = c_of(m);
      // R2 / R3 sequencing
      check(int'(cal_idx) == k, "R2 cal_idx", int'(cal_idx), k);
      check(fg_busy == fg_of(m), "R3 fg_busy", int'(fg_busy), int'(fg_of(m)));
      // R4 / R10 reference routing
      for (int i = 0; i < NC; i++)
        check(int'(ref_sel[i*RW +: RW]) == exp_ref(i, k), "R4 R10 ref_sel",
              int'(ref_sel[i*RW +: RW]), exp_ref(i, k));
      // R8 trial values, R9 results and holding
      if (c >= 1 && c <= SW)
        check(int'(trim[k*SW +: SW]) == trial_of(int'(tgt[k]), c), "R8 trial",
              int'(trim[k*SW +: SW]), trial_of(int'(tgt[k]), c));
      if (c == SW + 1) last_cal[k] = tgt[k];
      if (c > SW)
        check(trim[k*SW +: SW] == tgt[k], "R9 result", int'(trim[k*SW +: SW]), int'(tgt[k]));
      for (int i = 0; i < NC; i++)
        if (i != k)
          check(trim[i*SW +: SW] == last_cal[i], "R9 hold", int'(trim[i*SW +: SW]), int'(last_cal[i]));
      // R5 R6 R7 output of the previous sample
      if (m > 0) begin
        for (int j = 0; j < NT; j++) e_th[j] = (int'(p_vin) > j) ^ p_bub[j];
        check(therm == e_th, "R5 therm", int'(therm), int'(e_th));
        check(int'(code) == popc(e_th), "R6 code", int'(code), popc(e_th));
        check(code_valid == (!fg_of(m - 1) && c_of(m - 1) != 0), "R7 code_valid",
              int'(code_valid), int'(!fg_of(m - 1) && c_of(m - 1) != 0));
      end
      // new stimulus for this cycle
      if (c == 0 && !fg_of(m)) tgt[k] = SW'($urandom_range(0, 63));
      case (step % 23)
        0: vin = 5'd0;
        1: vin = 5'd15;
        default: vin = 5'($urandom_range(0, 15));
      endcase
      bub = '0;
      if ($urandom_range(0, 7) == 0) bub[$urandom_range(0, NT - 1)] = 1'b1;
      p_vin = vin;
      p_bub = bub;
      @(negedge clk);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * (RUN_CYC + 1000));
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", m, RUN_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule